// File: doc/BRIEF.md
# UART FIFO DMA Request Generator

This block drives the receive and transmit DMA request lines of a UART that has FIFOs in both directions. It watches the occupancy counts of both FIFOs and a receive character-timeout pulse. Each request is held in a register. It is raised by one condition and dropped by a different one, so the request line has hysteresis and does not toggle around a single threshold.

The configuration inputs control the thresholds:
- A FIFO depth select chooses 16 or 64 entries, and with it the table of trigger levels.
- A 2-bit trigger code picks the receive trigger level from that table.
- A select bit and a 2-bit extension field together pick the request mode (0 or 1) for each direction.
- A width bit chooses one-byte or two-byte DMA transfers.

A configuration change is only defined when it comes with a reinitialise strobe, which clears both requests. A prohibited mode combination drives both requests low and raises an error flag.

Top module: `uart_dma_req_gen`

## Requirements
- R1: With `deep_fifo`=0, trigger codes 0,1,2,3 select receive trigger levels of 1, 4, 8 and 14 entries.
- R2: With `deep_fifo`=1, trigger codes 0,1,2,3 select receive trigger levels of 1, 16, 32 and 56 entries.
- R3: The pair {`dma_sel`,`dma_ext`} decodes as follows: {0,00} gives rx mode 0 and tx mode 0; {1,00} gives rx 1 and tx 1; {0,01} gives rx 0 and tx 1; {1,10} gives rx 1 and tx 0. Every other pair raises `cfg_bad`, and both requests are low in the same cycle.
- R4: Receive mode 0 with byte width: the request sets when `rx_count`>=1 and releases when `rx_count`==0.
- R5: Receive mode 1 with byte width: the request sets when `rx_count` reaches the trigger level or `rx_timeout` is high. It releases only when `rx_count`==0.
- R6: With `wide_xfer`=1, a receive request in either mode sets only while `rx_count`>=2, and it releases when `rx_count`<=1.
- R7: Transmit mode 0: the request sets when `tx_count`==0. It releases when `tx_count`>=1 with byte width, and when `tx_count`>=2 with two-byte width.
- R8: Transmit mode 1: the request sets when `tx_count`==0 and releases only when `tx_count` reaches the selected depth (16 or 64).
- R9: A request changes one clock after the condition that causes it. It holds its value while neither its set nor its release condition is true. When both are true in the same cycle, the release wins.
- R10: A low `rst_n` or a high `cfg_reinit` at a clock edge clears both requests at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_reinit | input | 1 | Strobe that clears the request state after a configuration change |
| deep_fifo | input | 1 | 0: 16-entry FIFO, 1: 64-entry FIFO |
| trig_code | input | 2 | Receive trigger level code |
| dma_sel | input | 1 | Mode select bit |
| dma_ext | input | 2 | Mode extension field |
| wide_xfer | input | 1 | 0: one-byte DMA, 1: two-byte DMA |
| rx_count | input | CNT_W (7) | Receive FIFO occupancy |
| tx_count | input | CNT_W (7) | Transmit FIFO occupancy |
| rx_timeout | input | 1 | Receive character-timeout pulse |
| rx_req | output | 1 | Receive DMA request |
| tx_req | output | 1 | Transmit DMA request |
| cfg_bad | output | 1 | Prohibited mode combination |

## Verification
The bench builds the block with its default depths of 16 and 64 entries, which makes the count ports 7 bits wide. With those values, every trigger level in both tables can be reached exactly, and so can the full mark of either FIFO mode. Random occupancy walks up to the selected depth move each request repeatedly through its set, hold and release regions. Directed steps put each trigger level one entry below and exactly at its threshold, and drive set and release in the same cycle.

// File: rtl/uart_dma_pkg.sv
// Shared types for the UART DMA request generator.
package uart_dma_pkg;
    // Per-direction request mode: eager (0) or batched (1).
    typedef enum logic {
        REQ_MODE_EAGER = 1'b0,
        REQ_MODE_BATCH = 1'b1
    } req_mode_e;
endpackage

// File: rtl/uart_dma_trig_dec.sv
// Receive trigger threshold decoder.
// Turns the 2-bit trigger code into a count threshold, using one of two
// tables chosen by the FIFO depth select.
// Assumes CNT_W can hold DEEP_DEPTH.
module uart_dma_trig_dec #(
    parameter int SHALLOW_DEPTH = 16,
    parameter int DEEP_DEPTH    = 64,
    parameter int CNT_W         = $clog2(DEEP_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             deep_fifo,
    input  logic [1:0]       trig_code,
    output logic [CNT_W-1:0] trig_lvl,
    output logic [CNT_W-1:0] depth
);
    // Levels for codes 1..3 of each table; code 0 is always one entry.
    localparam int SH_L1 = SHALLOW_DEPTH / 4;
    localparam int SH_L2 = SHALLOW_DEPTH / 2;
    localparam int SH_L3 = SHALLOW_DEPTH - 2;
    localparam int DP_L1 = DEEP_DEPTH / 4;
    localparam int DP_L2 = DEEP_DEPTH / 2;
    localparam int DP_L3 = DEEP_DEPTH - 8;

    // Look up the threshold in the table that the depth select picks.
    always_comb begin
        unique case (trig_code)
            2'd0:    trig_lvl = CNT_W'(1);
            2'd1:    trig_lvl = deep_fifo ? CNT_W'(DP_L1) : CNT_W'(SH_L1);
            2'd2:    trig_lvl = deep_fifo ? CNT_W'(DP_L2) : CNT_W'(SH_L2);
            default: trig_lvl = deep_fifo ? CNT_W'(DP_L3) : CNT_W'(SH_L3);
        endcase
    end

    // Report the depth of the FIFO mode in use, for the full test.
    always_comb depth = deep_fifo ? CNT_W'(DEEP_DEPTH) : CNT_W'(SHALLOW_DEPTH);

    AST_TRIG_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_lvl >= CNT_W'(1)) && (trig_lvl <= depth)); // R1
    AST_TRIG_CODE0_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_code == 2'd0) |-> (trig_lvl == CNT_W'(1))); // R2
endmodule

// File: rtl/uart_dma_mode_dec.sv
// DMA mode decoder.
// Maps the select bit and the 2-bit extension field to a per-direction
// request mode, and flags every combination outside the four legal ones.
module uart_dma_mode_dec
    import uart_dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dma_sel,
    input  logic [1:0] dma_ext,
    output req_mode_e  rx_mode,
    output req_mode_e  tx_mode,
    output logic       bad
);
    // Decode the four legal combinations; default everything else to bad.
    always_comb begin
        rx_mode = REQ_MODE_EAGER;
        tx_mode = REQ_MODE_EAGER;
        bad     = 1'b0;
        unique case ({dma_sel, dma_ext})
            3'b0_00: ;
            3'b1_00: begin
                rx_mode = REQ_MODE_BATCH;
                tx_mode = REQ_MODE_BATCH;
            end
            3'b0_01: tx_mode = REQ_MODE_BATCH;
            3'b1_10: rx_mode = REQ_MODE_BATCH;
            default: bad = 1'b1;
        endcase
    end

    AST_EXT11_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ext == 2'b11) |-> bad); // R3
    AST_SPLIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bad && (rx_mode != tx_mode)) |-> (dma_ext != 2'b00)); // R3
endmodule

// File: rtl/uart_dma_rx_cond.sv
// Receive request condition logic.
// Works out the set and release conditions of the receive request from the
// occupancy, the trigger threshold, the timeout pulse, the mode and the width.
module uart_dma_rx_cond
    import uart_dma_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] trig_lvl,
    input  logic             timeout,
    input  req_mode_e        mode,
    input  logic             wide,
    output logic             set,
    output logic             rel
);
    localparam logic [CNT_W-1:0] MIN_WIDE = CNT_W'(2);

    logic enough;   // at least one transfer unit is stored
    logic event_hit;

    // Minimum stored count for one transfer of the selected width.
    always_comb enough = wide ? (cnt >= MIN_WIDE) : (cnt != '0);

    // Batched mode waits for the threshold or a timeout.
    always_comb event_hit = (cnt >= trig_lvl) || timeout;

    // Set once a unit is stored (plus the event in batched mode); release
    // once less than a unit remains.
    always_comb begin
        if (mode == REQ_MODE_BATCH) set = enough && event_hit;
        else                        set = enough;
        rel = !enough;
    end

    AST_RX_WIDE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (wide && set) |-> (cnt >= MIN_WIDE)); // R6
    AST_RX_BATCH_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == REQ_MODE_BATCH && !timeout && cnt < trig_lvl) |-> !set); // R5
endmodule

// File: rtl/uart_dma_tx_cond.sv
// Transmit request condition logic.
// The request sets on an empty FIFO. It releases at one or two stored
// entries in eager mode, and only at the full mark in batched mode.
module uart_dma_tx_cond
    import uart_dma_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] depth,
    input  req_mode_e        mode,
    input  logic             wide,
    output logic             set,
    output logic             rel
);
    logic [CNT_W-1:0] eager_mark;

    // Stored count at which eager mode stops asking.
    always_comb eager_mark = wide ? CNT_W'(2) : CNT_W'(1);

    // Set on empty; release at the mark that the mode selects.
    always_comb begin
        set = (cnt == '0);
        if (mode == REQ_MODE_BATCH) rel = (cnt >= depth);
        else                        rel = (cnt >= eager_mark);
    end

    AST_TX_SET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        set |-> (cnt == '0)); // R7
    AST_TX_BATCH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == REQ_MODE_BATCH && rel) |-> (cnt >= depth)); // R8
endmodule

// File: rtl/uart_dma_req_latch.sv
// Request set/release register.
// One flop per request. A clear or a release takes priority over a set,
// and the flop holds its value when nothing applies.
module uart_dma_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set,
    input  logic rel,
    output logic req_q
);
    // Update the request with clear > release > set > hold priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) req_q <= 1'b0;
        else if (rel)      req_q <= 1'b0;
        else if (set)      req_q <= 1'b1;
    end

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !req_q); // R10
    AST_RELEASE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rel |=> !req_q); // R9
    AST_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_q) |-> $past(set)); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !set && !rel) |=> $stable(req_q)); // R9
endmodule

// File: rtl/uart_dma_req_gen.sv
// UART FIFO DMA request generator (top).
// Decodes the configuration, forms the per-direction set and release
// conditions, and keeps one request register per direction. A prohibited
// mode gates both outputs low at once and clears the registers.
// Assumes configuration changes come together with cfg_reinit.
module uart_dma_req_gen
    import uart_dma_pkg::*;
#(
    parameter int SHALLOW_DEPTH = 16,
    parameter int DEEP_DEPTH    = 64,
    parameter int CNT_W         = $clog2(DEEP_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_reinit,
    input  logic             deep_fifo,
    input  logic [1:0]       trig_code,
    input  logic             dma_sel,
    input  logic [1:0]       dma_ext,
    input  logic             wide_xfer,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             rx_timeout,
    output logic             rx_req,
    output logic             tx_req,
    output logic             cfg_bad
);
    localparam int N_DIR = 2;   // index 0: receive, 1: transmit

    logic [CNT_W-1:0] trig_lvl;
    logic [CNT_W-1:0] depth;
    req_mode_e        rx_mode;
    req_mode_e        tx_mode;
    logic             bad;
    logic [N_DIR-1:0] set_v;
    logic [N_DIR-1:0] rel_v;
    logic [N_DIR-1:0] req_v;
    logic             clr_all;

    uart_dma_trig_dec #(
        .SHALLOW_DEPTH(SHALLOW_DEPTH),
        .DEEP_DEPTH   (DEEP_DEPTH),
        .CNT_W        (CNT_W)
    ) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .deep_fifo(deep_fifo),
        .trig_code(trig_code),
        .trig_lvl (trig_lvl),
        .depth    (depth)
    );

    uart_dma_mode_dec u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .dma_sel(dma_sel),
        .dma_ext(dma_ext),
        .rx_mode(rx_mode),
        .tx_mode(tx_mode),
        .bad    (bad)
    );

    uart_dma_rx_cond #(.CNT_W(CNT_W)) u_rx_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt     (rx_count),
        .trig_lvl(trig_lvl),
        .timeout (rx_timeout),
        .mode    (rx_mode),
        .wide    (wide_xfer),
        .set     (set_v[0]),
        .rel     (rel_v[0])
    );

    uart_dma_tx_cond #(.CNT_W(CNT_W)) u_tx_cond (
        .clk  (clk),
        .rst_n(rst_n),
        .cnt  (tx_count),
        .depth(depth),
        .mode (tx_mode),
        .wide (wide_xfer),
        .set  (set_v[1]),
        .rel  (rel_v[1])
    );

    // Clear the request state on a reinit strobe or a prohibited mode.
    always_comb clr_all = cfg_reinit || bad;

    // One set/release register per direction.
    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        uart_dma_req_latch u_latch (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (clr_all),
            .set  (set_v[d]),
            .rel  (rel_v[d]),
            .req_q(req_v[d])
        );
    end

    // Gate the outputs at once while the mode is prohibited.
    always_comb begin
        rx_req  = req_v[0] && !bad;
        tx_req  = req_v[1] && !bad;
        cfg_bad = bad;
    end

    AST_BAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bad |-> (!rx_req && !tx_req)); // R3
    AST_RX_EMPTY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |=> !rx_req); // R4
    AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count >= depth) |=> !tx_req); // R8
endmodule

// File: tb/tb_uart_dma_req_gen.sv
`timescale 1ns/1ps
module tb_uart_dma_req_gen;
    localparam int CNT_W = 7;

    logic             clk = 1'b0;
    logic             rst_n, cfg_reinit, deep_fifo, dma_sel, wide_xfer, rx_timeout;
    logic [1:0]       trig_code, dma_ext;
    logic [CNT_W-1:0] rx_count, tx_count;
    logic             rx_req, tx_req, cfg_bad;

    int checks = 0;
    int errors = 0;
    logic exp_rx = 1'b0;
    logic exp_tx = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    uart_dma_req_gen dut (.*);

    // Receive trigger level from the tables in R1 and R2.
    function automatic int f_trig(logic deep, logic [1:0] code);
        int sh[4] = '{1, 4, 8, 14};
        int dp[4] = '{1, 16, 32, 56};
        return deep ? dp[code] : sh[code];
    endfunction

    // Mode decode from R3: returns {bad, rx mode, tx mode}.
    function automatic logic [2:0] f_mode(logic s, logic [1:0] e);
        case ({s, e})
            3'b0_00: return 3'b000;
            3'b1_00: return 3'b011;
            3'b0_01: return 3'b001;
            3'b1_10: return 3'b010;
            default: return 3'b100;
        endcase
    endfunction

    // Update the expected request state at one clock edge.
    task automatic model_edge();
        logic [2:0] m = f_mode(dma_sel, dma_ext);
        int rc = int'(rx_count), tc = int'(tx_count);
        int dep = deep_fifo ? 64 : 16;
        int unit = wide_xfer ? 2 : 1;
        logic rs, rr, ts, tr;
        rr = rc < unit;
        rs = (rc >= unit) && (!m[1] || rc >= f_trig(deep_fifo, trig_code) || rx_timeout);
        ts = tc == 0;
        tr = m[0] ? (tc >= dep) : (tc >= unit);
        if (!rst_n || cfg_reinit || m[2]) begin
            exp_rx = 1'b0; exp_tx = 1'b0;
        end else begin
            if (rr) exp_rx = 1'b0; else if (rs) exp_rx = 1'b1;
            if (tr) exp_tx = 1'b0; else if (ts) exp_tx = 1'b1;
        end
    endtask

    task automatic chk(logic act, logic exp, string req, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // One clock: edge, model update, then check all outputs at the falling edge.
    task automatic cyc(string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(cfg_bad, f_mode(dma_sel, dma_ext) >> 2, req, "cfg_bad");
        chk(rx_req, exp_rx && !cfg_bad, req, "rx_req");
        chk(tx_req, exp_tx && !cfg_bad, req, "tx_req");
    endtask

    task automatic cfg(logic deep, logic [1:0] tc, logic s, logic [1:0] e, logic w);
        deep_fifo = deep; trig_code = tc; dma_sel = s; dma_ext = e; wide_xfer = w;
        cfg_reinit = 1'b1; cyc("R10");
        cfg_reinit = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; cfg_reinit = 1'b0; deep_fifo = 1'b0; trig_code = 2'd0;
        dma_sel = 1'b0; dma_ext = 2'b00; wide_xfer = 1'b0; rx_timeout = 1'b0;
        rx_count = 7'd5; tx_count = 7'd0;
        @(negedge clk);
        cyc("R10"); cyc("R10");          // reset state: both requests low
        rst_n = 1'b1;
        cyc("R7");                       // tx empty -> request one clock later
        chk(tx_req, 1'b1, "R7", "tx set after empty");

        // R1 / R2: each trigger level, one below and exactly at threshold
        for (int dp = 0; dp < 2; dp++)
            for (int c = 0; c < 4; c++) begin
                cfg(dp[0], c[1:0], 1'b1, 2'b00, 1'b0);
                rx_count = CNT_W'(f_trig(dp[0], c[1:0]) - 1);
                cyc(dp ? "R2" : "R1");
                if (f_trig(dp[0], c[1:0]) > 1) chk(rx_req, 1'b0, dp ? "R2" : "R1", "below trig");
                rx_count = CNT_W'(f_trig(dp[0], c[1:0]));
                cyc(dp ? "R2" : "R1");
                chk(rx_req, 1'b1, dp ? "R2" : "R1", "at trig");
                rx_count = 7'd0;
                cyc("R5");
            end

        // R5: timeout sets below threshold; holds above empty
        cfg(1'b0, 2'd3, 1'b1, 2'b00, 1'b0);
        rx_count = 7'd2; rx_timeout = 1'b1; cyc("R5"); chk(rx_req, 1'b1, "R5", "timeout set");
        rx_timeout = 1'b0; rx_count = 7'd1; cyc("R5"); chk(rx_req, 1'b1, "R5", "hold");
        rx_count = 7'd0; rx_timeout = 1'b1; cyc("R9"); chk(rx_req, 1'b0, "R9", "release wins");
        rx_timeout = 1'b0;

        // R4: eager byte mode
        cfg(1'b0, 2'd3, 1'b0, 2'b00, 1'b0);
        rx_count = 7'd1; cyc("R4"); chk(rx_req, 1'b1, "R4", "one byte");
        rx_count = 7'd0; cyc("R4"); chk(rx_req, 1'b0, "R4", "empty");

        // R6: two-byte width
        cfg(1'b0, 2'd0, 1'b1, 2'b00, 1'b1);
        rx_count = 7'd1; rx_timeout = 1'b1; cyc("R6"); chk(rx_req, 1'b0, "R6", "one byte wide");
        rx_timeout = 1'b0; rx_count = 7'd2; cyc("R6"); chk(rx_req, 1'b1, "R6", "two bytes");
        rx_count = 7'd1; cyc("R6"); chk(rx_req, 1'b0, "R6", "drop at one");

        // R7 / R8: transmit release marks
        cfg(1'b0, 2'd0, 1'b0, 2'b00, 1'b1);
        tx_count = 7'd0; cyc("R7"); tx_count = 7'd1; cyc("R7");
        chk(tx_req, 1'b1, "R7", "wide hold at 1");
        tx_count = 7'd2; cyc("R7"); chk(tx_req, 1'b0, "R7", "wide drop at 2");
        cfg(1'b1, 2'd0, 1'b0, 2'b01, 1'b0);
        tx_count = 7'd0; cyc("R8"); tx_count = 7'd63; cyc("R8");
        chk(tx_req, 1'b1, "R8", "hold below full");
        tx_count = 7'd64; cyc("R8"); chk(tx_req, 1'b0, "R8", "drop at full");

        // R3: prohibited combination gates both outputs at once
        tx_count = 7'd0; rx_count = 7'd9; cyc("R3");
        dma_ext = 2'b11; #1;
        chk(cfg_bad, 1'b1, "R3", "bad flag"); chk(tx_req, 1'b0, "R3", "tx gated");
        cyc("R3");
        dma_ext = 2'b01; cfg_reinit = 1'b1; cyc("R10"); cfg_reinit = 1'b0;

        // Random walk over counts and configurations
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 99) < 3) begin
                int k = $urandom_range(0, 4);
                logic [2:0] se = (k == 0) ? 3'b000 : (k == 1) ? 3'b100 :
                                 (k == 2) ? 3'b001 : (k == 3) ? 3'b110 : 3'($urandom);
                cfg(1'($urandom), 2'($urandom), se[2], se[1:0], 1'($urandom));
            end
            begin
                int dep = deep_fifo ? 64 : 16;
                int nr = int'(rx_count) + $urandom_range(0, 2) - 1;
                int nt = int'(tx_count) + $urandom_range(0, 2) - 1;
                if ($urandom_range(0, 49) == 0) nt = dep;
                if ($urandom_range(0, 49) == 0) nr = 0;
                rx_count = CNT_W'(nr < 0 ? 0 : (nr > dep ? dep : nr));
                tx_count = CNT_W'(nt < 0 ? 0 : (nt > dep ? dep : nt));
                rx_timeout = ($urandom_range(0, 19) == 0);
                cfg_reinit = ($urandom_range(0, 199) == 0);
            end
            cyc("R9");
        end
        cfg_reinit = 1'b0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule